// File: doc/BRIEF.md
# Translation Cache with Page Table Walker

This block turns a 32-bit virtual address into a physical address. The upper 20 bits are the page number and the low 12 bits are the byte offset inside a 4 KB page. Recent translations are held in a small fully associative cache. On a hit, the cached frame number is joined to the offset and no page-table memory is touched. On a miss, the block reads one page table entry (PTE) from memory, checks it, installs it in the cache and completes the access.

Each PTE is a 32-bit word. Bits 31:12 hold the frame number. The flag bits are:

| Bit | Meaning |
|-----|---------|
| 0 | valid |
| 1 | referenced |
| 2 | modified |
| 3 | read allowed |
| 4 | write allowed |
| 5 | execute allowed |

Every permitted access updates the referenced and modified bits. An entry that changes is written back to the table before the access is answered. Faults are reported with a code and are not serviced here. The table base, the table length and a flush line come from the surrounding context-switch logic.

Top module: `tlb_walker`

## Requirements
- R1: On success `resp_paddr` is {PTE[31:12], vaddr[11:0]}. On any fault `resp_paddr` is zero. Fault codes are 0 none, 1 out of range, 2 not present, 3 refused.
- R2: A request whose page is cached makes no memory access. If no flag update is needed, `resp_valid` rises two clock edges after the acceptance edge.
- R3: A request whose page is not cached makes exactly one read, at word address `cfg_ptbr` + page number. A present PTE is then cached for later requests.
- R4: A page number not less than `cfg_ptlen` gets fault code 1. It makes no memory access, and the response follows one edge after acceptance.
- R5: A fetched PTE with bit 0 clear gets fault code 2 and is not cached. A repeat of the request reads memory again.
- R6: Access kind 0 (read) needs bit 3, kind 1 (write) needs bit 4 and kind 2 (execute) needs bit 5. Kind 3 is always refused. A refused access gets fault code 3 and changes no flag.
- R7: A permitted access sets bit 1. A permitted write also sets bit 2. When this changes the PTE, the new word is written to the same table address before the response.
- R8: A permitted access that changes no flag makes no memory write.
- R9: The cache holds 8 entries and fills them in round-robin order. After 8 distinct fills, the next fill evicts the oldest fill.
- R10: A one-cycle pulse on `flush` invalidates every cached entry, so the next request to any page reads memory.
- R11: A memory request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` steady until the edge where `mem_ack` is high. Only one request is outstanding at a time.
- R12: `req_ready` is high only while idle. `resp_valid` is a one-cycle pulse for each accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Invalidate all cached translations |
| cfg_ptbr | input | 32 | Page table base word address |
| cfg_ptlen | input | 21 | Number of pages in the table |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Block idle, request accepted |
| req_vaddr | input | 32 | Virtual address |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| resp_valid | output | 1 | Response pulse |
| resp_paddr | output | 32 | Physical address |
| resp_fault | output | 2 | Fault code |
| mem_req | output | 1 | Table memory request |
| mem_we | output | 1 | Table memory write |
| mem_addr | output | 32 | Table word address |
| mem_wdata | output | 32 | PTE written back |
| mem_ack | input | 1 | Memory completes request this edge |
| mem_rdata | input | 32 | PTE read, valid with `mem_ack` |

## Verification
A range fault is answered one edge after acceptance. A cached hit that needs no flag update is answered two edges after acceptance. Any path that touches memory adds the memory's acknowledge delay: one edge from the acknowledge to evaluation, plus a second memory cycle when a write-back is needed. The bench drives on falling edges and samples every falling edge after acceptance, counting edges until `resp_valid` appears. It checks that count exactly only for the two fixed-latency cases. For the other cases it counts the reads and writes the memory model served and compares them with the expected count.

// File: rtl/tlbw_pkg.sv
package tlbw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WALK,
        ST_EVAL,
        ST_WB,
        ST_RESP
    } walk_st_e;

    localparam logic [1:0] ACC_LOAD  = 2'd0;
    localparam logic [1:0] ACC_STORE = 2'd1;
    localparam logic [1:0] ACC_FETCH = 2'd2;

    localparam logic [1:0] FLT_OK     = 2'd0;
    localparam logic [1:0] FLT_RANGE  = 2'd1;
    localparam logic [1:0] FLT_ABSENT = 2'd2;
    localparam logic [1:0] FLT_PERM   = 2'd3;

    localparam int unsigned B_VALID = 0;
    localparam int unsigned B_REF   = 1;
    localparam int unsigned B_MOD   = 2;
    localparam int unsigned B_RD    = 3;
    localparam int unsigned B_WR    = 4;
    localparam int unsigned B_EX    = 5;
endpackage

// File: rtl/tlbw_perm.sv
module tlbw_perm
    import tlbw_pkg::*;
#(
    parameter int PTE_W = 32
) (
    input  logic [PTE_W-1:0] pte,
    input  logic [1:0]       acc,
    output logic             allow,
    output logic [PTE_W-1:0] pte_next,
    output logic             touched
);
    always_comb begin
        case (acc)
            ACC_LOAD:  allow = pte[B_RD];
            ACC_STORE: allow = pte[B_WR];
            ACC_FETCH: allow = pte[B_EX];
            default:   allow = 1'b0;
        endcase
        pte_next        = pte;
        pte_next[B_REF] = 1'b1;
        if (acc == ACC_STORE) begin
            pte_next[B_MOD] = 1'b1;
        end
        touched = (pte_next != pte);
    end
endmodule

// File: rtl/tlbw_cam.sv
module tlbw_cam #(
    parameter int ENTRIES = 8,
    parameter int VPN_W   = 20,
    parameter int PTE_W   = 32,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] look_vpn,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [PTE_W-1:0] hit_pte,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VPN_W-1:0] wr_vpn,
    input  logic [PTE_W-1:0] wr_pte
);
    typedef struct packed {
        logic             vld;
        logic [VPN_W-1:0] vpn;
        logic [PTE_W-1:0] pte;
    } ent_t;

    ent_t               ent_d [ENTRIES];
    ent_t               ent_q [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] vld_vec;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign match[g]   = ent_q[g].vld && (ent_q[g].vpn == look_vpn);
        assign vld_vec[g] = ent_q[g].vld;
    end

    always_comb begin
        hit     = |match;
        hit_idx = '0;
        hit_pte = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_idx = IDX_W'(i);
                hit_pte = ent_q[i].pte;
            end
        end
    end

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            ent_d[i] = ent_q[i];
        end
        if (wr_en) begin
            ent_d[wr_idx] = '{vld: 1'b1, vpn: wr_vpn, pte: wr_pte};
        end
        if (flush) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_d[i].vld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < ENTRIES; i++) begin
                ent_q[i] <= ent_d[i];
            end
        end
    end

    a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    a_r10_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (vld_vec == '0));
endmodule

// File: rtl/tlbw_fsm.sv
module tlbw_fsm
    import tlbw_pkg::*;
#(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int ENTRIES = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PA_W-1:0]  cfg_ptbr,
    input  logic [VPN_W:0]   cfg_ptlen,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_acc,
    output logic             resp_valid,
    output logic [PA_W-1:0]  resp_paddr,
    output logic [1:0]       resp_fault,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PA_W-1:0]  mem_addr,
    output logic [PA_W-1:0]  mem_wdata,
    input  logic             mem_ack,
    input  logic [PA_W-1:0]  mem_rdata,
    input  logic             cam_hit,
    input  logic [IDX_W-1:0] cam_idx,
    input  logic [PA_W-1:0]  cam_pte,
    output logic             cam_wr_en,
    output logic [IDX_W-1:0] cam_wr_idx,
    output logic [VPN_W-1:0] cam_wr_vpn,
    output logic [PA_W-1:0]  cam_wr_pte
);
    typedef struct packed {
        walk_st_e         st;
        logic [VA_W-1:0]  va;
        logic [1:0]       acc;
        logic [PA_W-1:0]  pte;
        logic [IDX_W-1:0] idx;
        logic [IDX_W-1:0] rr;
        logic [1:0]       flt;
    } ctl_t;

    ctl_t             ctl_d, ctl_q;
    logic             allow;
    logic             touched;
    logic [PA_W-1:0]  pte_next;
    logic [VPN_W-1:0] req_vpn;
    logic [VPN_W-1:0] cur_vpn;
    logic             out_of_range;

    assign req_vpn      = req_vaddr[VA_W-1:OFF_W];
    assign cur_vpn      = ctl_q.va[VA_W-1:OFF_W];
    assign out_of_range = ({1'b0, req_vpn} >= cfg_ptlen);

    tlbw_perm #(.PTE_W(PA_W)) u_perm (
        .pte      (ctl_q.pte),
        .acc      (ctl_q.acc),
        .allow    (allow),
        .pte_next (pte_next),
        .touched  (touched)
    );

    always_comb begin
        ctl_d      = ctl_q;
        cam_wr_en  = 1'b0;
        cam_wr_idx = ctl_q.idx;
        cam_wr_pte = ctl_q.pte;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.va  = req_vaddr;
                    ctl_d.acc = req_acc;
                    ctl_d.flt = FLT_OK;
                    if (out_of_range) begin
                        ctl_d.flt = FLT_RANGE;
                        ctl_d.st  = ST_RESP;
                    end else if (cam_hit) begin
                        ctl_d.pte = cam_pte;
                        ctl_d.idx = cam_idx;
                        ctl_d.st  = ST_EVAL;
                    end else begin
                        ctl_d.st = ST_WALK;
                    end
                end
            end
            ST_WALK: begin
                if (mem_ack) begin
                    if (!mem_rdata[B_VALID]) begin
                        ctl_d.flt = FLT_ABSENT;
                        ctl_d.st  = ST_RESP;
                    end else begin
                        ctl_d.pte  = mem_rdata;
                        ctl_d.idx  = ctl_q.rr;
                        ctl_d.rr   = (ctl_q.rr == IDX_W'(ENTRIES - 1)) ? '0 : ctl_q.rr + 1'b1;
                        cam_wr_en  = 1'b1;
                        cam_wr_idx = ctl_q.rr;
                        cam_wr_pte = mem_rdata;
                        ctl_d.st   = ST_EVAL;
                    end
                end
            end
            ST_EVAL: begin
                if (!allow) begin
                    ctl_d.flt = FLT_PERM;
                    ctl_d.st  = ST_RESP;
                end else if (touched) begin
                    ctl_d.pte  = pte_next;
                    cam_wr_en  = 1'b1;
                    cam_wr_pte = pte_next;
                    ctl_d.st   = ST_WB;
                end else begin
                    ctl_d.st = ST_RESP;
                end
            end
            ST_WB: begin
                if (mem_ack) begin
                    ctl_d.st = ST_RESP;
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cam_wr_vpn = cur_vpn;
    assign req_ready  = (ctl_q.st == ST_IDLE);
    assign resp_valid = (ctl_q.st == ST_RESP);
    assign resp_fault = ctl_q.flt;
    assign resp_paddr = (ctl_q.flt == FLT_OK) ?
                        {ctl_q.pte[PA_W-1:OFF_W], ctl_q.va[OFF_W-1:0]} : '0;
    assign mem_req    = (ctl_q.st == ST_WALK) || (ctl_q.st == ST_WB);
    assign mem_we     = (ctl_q.st == ST_WB);
    assign mem_addr   = cfg_ptbr + PA_W'(cur_vpn);
    assign mem_wdata  = ctl_q.pte;

    a_r12_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    a_r12_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                   && $stable(mem_wdata)));

    a_r4_range_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && out_of_range) |=>
            (resp_valid && resp_fault == FLT_RANGE && !mem_req));

    a_r2_hit_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !out_of_range && cam_hit) |=> !mem_req);
endmodule

// File: rtl/tlb_walker.sv
module tlb_walker #(
    parameter int VA_W    = 32,
    parameter int PA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int ENTRIES = 8,
    localparam int VPN_W  = VA_W - OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [PA_W-1:0] cfg_ptbr,
    input  logic [VPN_W:0]  cfg_ptlen,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [1:0]      req_acc,
    output logic            resp_valid,
    output logic [PA_W-1:0] resp_paddr,
    output logic [1:0]      resp_fault,
    output logic            mem_req,
    output logic            mem_we,
    output logic [PA_W-1:0] mem_addr,
    output logic [PA_W-1:0] mem_wdata,
    input  logic            mem_ack,
    input  logic [PA_W-1:0] mem_rdata
);
    logic             cam_hit;
    logic [IDX_W-1:0] cam_idx;
    logic [PA_W-1:0]  cam_pte;
    logic             cam_wr_en;
    logic [IDX_W-1:0] cam_wr_idx;
    logic [VPN_W-1:0] cam_wr_vpn;
    logic [PA_W-1:0]  cam_wr_pte;

    tlbw_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PTE_W(PA_W)) u_cam (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .look_vpn (req_vaddr[VA_W-1:OFF_W]),
        .hit      (cam_hit),
        .hit_idx  (cam_idx),
        .hit_pte  (cam_pte),
        .wr_en    (cam_wr_en),
        .wr_idx   (cam_wr_idx),
        .wr_vpn   (cam_wr_vpn),
        .wr_pte   (cam_wr_pte)
    );

    tlbw_fsm #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W), .ENTRIES(ENTRIES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_ptbr   (cfg_ptbr),
        .cfg_ptlen  (cfg_ptlen),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_vaddr  (req_vaddr),
        .req_acc    (req_acc),
        .resp_valid (resp_valid),
        .resp_paddr (resp_paddr),
        .resp_fault (resp_fault),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_ack    (mem_ack),
        .mem_rdata  (mem_rdata),
        .cam_hit    (cam_hit),
        .cam_idx    (cam_idx),
        .cam_pte    (cam_pte),
        .cam_wr_en  (cam_wr_en),
        .cam_wr_idx (cam_wr_idx),
        .cam_wr_vpn (cam_wr_vpn),
        .cam_wr_pte (cam_wr_pte)
    );
endmodule

// File: tb/tb_tlb_walker.sv
module tb_tlb_walker;
    localparam int CLK_PERIOD = 10;
    localparam int NPAGE      = 64;
    localparam logic [31:0] PTBR = 32'h0000_0400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_acc = '0;
    logic        req_ready, resp_valid, mem_req, mem_we;
    logic [31:0] resp_paddr, mem_addr, mem_wdata;
    logic [1:0]  resp_fault;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tlb_walker dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .cfg_ptbr(PTBR), .cfg_ptlen(21'(NPAGE)),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_acc(req_acc), .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_fault(resp_fault), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata)
    );

    int checks = 0;
    int errors = 0;
    int rd_cnt = 0;
    int wr_cnt = 0;
    int last_rd, last_wr;
    bit done = 0;

    logic [31:0] pt_mem [NPAGE];
    logic [31:0] pt_exp [NPAGE];
    bit          m_vld  [8];
    logic [19:0] m_vpn  [8];
    logic [31:0] m_pte  [8];
    int          m_rr = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // memory model: random acknowledge delay, R11 hold check
    int          wait_cnt = 0;
    bit          pend = 0;
    logic [31:0] pend_addr;
    logic        pend_we;
    always @(negedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && !mem_ack) begin
            if (pend) begin
                check(mem_addr == pend_addr && mem_we == pend_we, "R11",
                      "request changed before acknowledge", mem_addr, pend_addr);
            end
            pend      = 1;
            pend_addr = mem_addr;
            pend_we   = mem_we;
            if (wait_cnt == 0) begin
                int idx;
                idx = int'(mem_addr - PTBR);
                check(mem_addr >= PTBR && idx < NPAGE, "R3", "table address",
                      mem_addr, PTBR);
                mem_ack <= 1'b1;
                pend     = 0;
                wait_cnt = $urandom % 3;
                if (idx >= 0 && idx < NPAGE) begin
                    if (mem_we) begin
                        pt_mem[idx] = mem_wdata;
                        wr_cnt++;
                    end else begin
                        mem_rdata <= pt_mem[idx];
                        rd_cnt++;
                    end
                end
            end else begin
                wait_cnt--;
            end
        end
    end

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 8; i++) m_vld[i] = 0;
    endtask

    task automatic access(input logic [31:0] va, input logic [1:0] acc);
        logic [19:0] vpn;
        logic [1:0]  e_flt;
        logic [31:0] e_pa, p, np;
        int e_rd, e_wr, e_lat, hi, rd0, wr0, lat;
        bit hit, ok;
        string ftag;
        vpn = va[31:12];
        e_flt = 0; e_pa = 0; e_rd = 0; e_wr = 0; e_lat = 0; hi = 0; hit = 0;
        if (vpn >= NPAGE) begin
            e_flt = 1; e_lat = 1;
        end else begin
            for (int i = 0; i < 8; i++)
                if (m_vld[i] && m_vpn[i] == vpn) begin hit = 1; hi = i; end
            if (!hit) begin
                e_rd = 1;
                p = pt_exp[vpn];
                if (!p[0]) e_flt = 2;
                else begin
                    hi = m_rr; m_vld[hi] = 1; m_vpn[hi] = vpn; m_pte[hi] = p;
                    m_rr = (m_rr + 1) % 8;
                end
            end
            if (e_flt == 0) begin
                p = m_pte[hi];
                ok = (acc == 0) ? p[3] : (acc == 1) ? p[4] : (acc == 2) ? p[5] : 1'b0;
                if (!ok) e_flt = 3;
                else begin
                    np = p | 32'h2 | ((acc == 1) ? 32'h4 : 32'h0);
                    if (np != p) begin
                        e_wr = 1; m_pte[hi] = np; pt_exp[vpn] = np;
                    end else if (hit) e_lat = 2;
                    e_pa = {np[31:12], va[11:0]};
                end
            end
        end
        @(negedge clk);
        check(req_ready == 1'b1, "R12", "ready while idle", 32'(req_ready), 32'd1);
        rd0 = rd_cnt; wr0 = wr_cnt;
        req_valid = 1'b1; req_vaddr = va; req_acc = acc;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!resp_valid && lat < 100) begin
            check(req_ready == 1'b0, "R12", "ready while busy", 32'(req_ready), 32'd0);
            @(negedge clk);
            lat++;
        end
        last_rd = rd_cnt - rd0;
        last_wr = wr_cnt - wr0;
        ftag = (e_flt == 1) ? "R4" : (e_flt == 2) ? "R5" : (e_flt == 3) ? "R6" : "R3";
        check(resp_valid, "R12", "response missing", 32'(lat), 32'd0);
        check(resp_fault == e_flt, ftag, "fault code", 32'(resp_fault), 32'(e_flt));
        check(resp_paddr == e_pa, "R1", "physical address", resp_paddr, e_pa);
        check(last_rd == e_rd, (e_rd != 0) ? "R3" : "R2", "table reads",
              32'(last_rd), 32'(e_rd));
        check(last_wr == e_wr, (e_wr != 0) ? "R7" : "R8", "table writes",
              32'(last_wr), 32'(e_wr));
        if (e_lat != 0)
            check(lat == e_lat, (e_lat == 1) ? "R4" : "R2", "latency",
                  32'(lat), 32'(e_lat));
        if (vpn < NPAGE)
            check(pt_mem[vpn] == pt_exp[vpn], "R7", "stored entry",
                  pt_mem[vpn], pt_exp[vpn]);
        @(negedge clk);
        check(!resp_valid, "R12", "response pulse width", 32'(resp_valid), 32'd0);
    endtask

    function automatic logic [31:0] mk(input int pg, input logic [5:0] fl);
        return {20'(32'h80 + pg), 6'b0, fl};
    endfunction

    initial begin
        int cyc;
        cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 8; i++) m_vld[i] = 0;
        for (int i = 0; i < NPAGE; i++) pt_mem[i] = mk(i, 6'h39);
        pt_mem[5] = mk(5, 6'h38);
        pt_mem[6] = mk(6, 6'h09);
        pt_mem[7] = mk(7, 6'h21);
        pt_mem[8] = mk(8, 6'h3F);
        for (int i = 0; i < NPAGE; i++) pt_exp[i] = pt_mem[i];
        repeat (3) @(negedge clk);
        check(req_ready && !resp_valid && !mem_req, "R12", "reset state",
              {29'b0, req_ready, resp_valid, mem_req}, 32'h4);
        rst_n = 1'b1;

        access(32'h0000_1ABC, 2'd0);   // miss, referenced set
        access(32'h0000_1004, 2'd0);   // hit, no update
        access(32'h0000_1010, 2'd1);   // hit, modified set
        access(32'h0000_1FFF, 2'd1);   // hit, no update
        access(32'h0000_8123, 2'd0);   // flags already set
        access(32'h0000_5000, 2'd0);   // not present
        access(32'h0000_5000, 2'd0);   // R5 not cached, reads again
        access(32'h0000_6000, 2'd1);   // write to read-only
        access(32'h0000_6000, 2'd0);
        access(32'h0000_7000, 2'd2);
        access(32'h0000_7000, 2'd0);   // read of execute-only
        access(32'h0000_2000, 2'd3);   // reserved kind
        access(32'h0004_0000, 2'd0);   // page 64: out of range
        access(32'hFFFF_F000, 2'd2);

        do_flush();
        access(32'h0000_1000, 2'd0);
        check(last_rd == 1, "R10", "read after flush", 32'(last_rd), 32'd1);

        do_flush();
        for (int i = 10; i < 18; i++) access({20'(i), 12'h0}, 2'd0);
        access(32'h0000_A000, 2'd0);
        check(last_rd == 0, "R9", "oldest still cached", 32'(last_rd), 32'd0);
        access(32'h0001_2000, 2'd0);   // ninth fill evicts page 10
        access(32'h0000_A000, 2'd0);
        check(last_rd == 1, "R9", "oldest evicted", 32'(last_rd), 32'd1);

        do_flush();
        for (int i = 20; i < NPAGE; i++) begin
            logic [5:0] fl;
            fl = 6'($urandom % 64);
            if ($urandom % 8 != 0) fl[0] = 1'b1;
            pt_mem[i] = {20'($urandom), 6'b0, fl};
            pt_exp[i] = pt_mem[i];
        end
        for (int n = 0; n < 400; n++) begin
            if ($urandom % 20 == 0) do_flush();
            access({20'(20 + $urandom % 50), 12'($urandom)}, 2'($urandom % 3));
        end
        finish_run();
    end
endmodule